// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, frame by frame, whether a received Ethernet frame should be kept, looking only at its destination address. The receive path hands it the address one byte at a time, flagging the first byte with a start strobe. While the bytes arrive, the block runs an Ethernet CRC-32 over them, compares them with the programmed station address, and records whether the address is multicast or broadcast. One cycle after the last address byte, it presents a keep/drop verdict together with a single-cycle valid strobe.

The verdict depends on six static control inputs. These select promiscuous reception, acceptance of every multicast, hash filtering of multicast with exact unicast matching, hash filtering of all frames, inversion of the unicast exact-match result, and blocking of broadcast. A 64-bit hash table is supplied as two 32-bit words. The top six bits of the CRC pick one bit of that table.

The controller has three states. `ST_IDLE` waits for a start strobe. `ST_COLLECT` counts address bytes and allows idle gaps between them. `ST_DECIDE` lasts exactly one cycle and drives the verdict. The transitions are:
- start (from any state, into `ST_COLLECT`);
- next-byte (stays in `ST_COLLECT`);
- last-byte (`ST_COLLECT` to `ST_DECIDE`);
- done (`ST_DECIDE` to `ST_IDLE`);
- back-to-back start (`ST_DECIDE` straight to `ST_COLLECT`).

Top module: `dstaddr_filter`

## Requirements
- R1: While reset is asserted, and after it is released, `decision_valid` is low until a complete address has been received.
- R2: `decision_valid` is high for exactly one cycle. That cycle directly follows the clock edge that takes the sixth address byte, however many idle cycles separate the bytes.
- R3: The hash index is bits 31..26 of a CRC computed over the 48 address bits in arrival order, least significant bit of each byte first. The CRC uses polynomial 0x04C11DB7, starts from all ones, and is not inverted. Index bit 5 = 1 selects `hash_hi`, and 0 selects `hash_lo`. Index bits 4..0 select the bit within that word, and the hash test passes when that bit is 1.
- R4: With `mode_promisc` = 1, every frame is accepted whatever the other control inputs are.
- R5: The broadcast address (all 48 bits one) is accepted unless `mode_bcast_block` = 1, in which case it is rejected (outside promiscuous mode).
- R6: With `mode_all_mcast` = 1, every non-broadcast multicast destination is accepted without consulting the hash table.
- R7: With `mode_hash_perfect` = 1, a multicast destination is accepted on a hash hit, and a unicast destination on an exact station-address match.
- R8: With all mode inputs 0, only an exact station-address match and broadcast are accepted. Multicast is rejected.
- R9: With `mode_hash_only` = 1, unicast destinations are also judged by the hash test instead of the station address. Multicast is judged by the hash test as in R7.
- R10: `mode_inverse` = 1 inverts the exact-match result for unicast frames. It has no effect in promiscuous mode, on hash-judged frames, or on multicast.
- R11: A start strobe during collection discards the partial address and begins a new one. Bytes offered without a start strobe while idle are ignored and produce no verdict.
- R12: The first address byte received is compared with `station_addr[7:0]`, the k-th with `station_addr[8k+7:8k]`. A destination is multicast when bit 0 of its first byte is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_start | input | 1 | Marks the current byte as the first address byte |
| addr_valid | input | 1 | `addr_byte` carries an address byte this cycle |
| addr_byte | input | 8 | Destination address byte |
| station_addr | input | 48 | Station address, first received byte in bits 7..0 |
| hash_lo | input | 32 | Hash table bits 0..31 |
| hash_hi | input | 32 | Hash table bits 32..63 |
| mode_promisc | input | 1 | Accept every frame |
| mode_all_mcast | input | 1 | Accept every multicast frame |
| mode_hash_perfect | input | 1 | Hash for multicast, exact match for unicast |
| mode_hash_only | input | 1 | Hash for unicast as well |
| mode_inverse | input | 1 | Invert the unicast exact-match result |
| mode_bcast_block | input | 1 | Reject broadcast |
| frame_accept | output | 1 | Verdict, meaningful while `decision_valid` is high |
| decision_valid | output | 1 | One-cycle strobe marking the verdict |

## Verification
The assertions watch the timing and shape of the verdict on every cycle. They check that it is a single-cycle pulse, that it always follows a taken byte, and that the byte counter stays within range. They also check the priority rules that can be read from ports and flags: promiscuous acceptance, broadcast handling, and rejection of multicast in the default mode. Only the bench scenarios can show that the CRC index lands on the right hash-table bit, that the byte order against the station address is correct, that inversion and hash-only modes combine as specified, and that aborted or start-less byte streams are handled. For that, the bench sweeps all 64 mode combinations against several addresses and hash tables, and compares each verdict with an independent model.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2
    } daf_state_e;

    typedef struct packed {
        logic promisc;
        logic all_mcast;
        logic hash_perfect;
        logic hash_only;
        logic inverse;
        logic bcast_block;
    } daf_mode_t;

    // Advance the CRC by one byte, least significant data bit first
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                             input logic [7:0]  data);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[31] ^ data[b];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/daf_fsm.sv
module daf_fsm
    import daf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_start,
    input  logic             in_valid,
    output logic             take,
    output logic             first,
    output logic [CNT_W-1:0] byte_idx,
    output logic             dec_valid
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES);

    daf_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_start) begin
                    cnt_n   = CNT_W'(1);
                    state_n = (ADDR_BYTES == 1) ? ST_DECIDE : ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (in_valid && in_start) begin
                    cnt_n   = CNT_W'(1);
                    state_n = (ADDR_BYTES == 1) ? ST_DECIDE : ST_COLLECT;
                end else if (in_valid) begin
                    cnt_n = cnt_q + CNT_W'(1);
                    if (cnt_n == LAST_CNT) state_n = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                if (in_valid && in_start) begin
                    cnt_n   = CNT_W'(1);
                    state_n = (ADDR_BYTES == 1) ? ST_DECIDE : ST_COLLECT;
                end else begin
                    cnt_n   = '0;
                    state_n = ST_IDLE;
                end
            end
            default: begin
                cnt_n   = '0;
                state_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        first     = in_valid && in_start;
        take      = in_valid && (in_start || state_q == ST_COLLECT);
        byte_idx  = first ? '0 : cnt_q;
        dec_valid = (state_q == ST_DECIDE);
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !(ADDR_BYTES == 1) |=> !dec_valid);

    // R2
    decide_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(take) |-> !dec_valid);

endmodule

// File: rtl/daf_crc.sv
module daf_crc
    import daf_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             first,
    input  logic [7:0]       data,
    output logic [IDX_W-1:0] hash_idx
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (take) begin
            crc_q <= crc_step(first ? CRC_SEED : crc_q, data);
        end
    end

    assign hash_idx = crc_q[31 -: IDX_W];

endmodule

// File: rtl/daf_capture.sv
module daf_capture #(
    parameter int ADDR_BYTES = 6,
    localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    first,
    input  logic [CNT_W-1:0]        byte_idx,
    input  logic [7:0]              data,
    input  logic [ADDR_BYTES*8-1:0] station,
    output logic                    is_match,
    output logic                    is_bcast,
    output logic                    is_mcast
);

    logic [7:0] sta_byte;
    logic       match_q, bcast_q, mcast_q;

    always_comb begin
        sta_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (byte_idx == CNT_W'(k)) sta_byte = station[k*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            bcast_q <= 1'b0;
            mcast_q <= 1'b0;
        end else if (take) begin
            match_q <= (first || match_q) && (data == sta_byte);
            bcast_q <= (first || bcast_q) && (data == 8'hFF);
            if (first) mcast_q <= data[0];
        end
    end

    assign is_match = match_q;
    assign is_bcast = bcast_q;
    assign is_mcast = mcast_q;

endmodule

// File: rtl/daf_decide.sv
module daf_decide
    import daf_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int WORD_W = 2 ** (IDX_W - 1)
) (
    input  daf_mode_t        mode,
    input  logic [IDX_W-1:0] hash_idx,
    input  logic [WORD_W-1:0] table_lo,
    input  logic [WORD_W-1:0] table_hi,
    input  logic             is_match,
    input  logic             is_bcast,
    input  logic             is_mcast,
    output logic             accept
);

    logic [WORD_W-1:0] word;
    logic              hash_hit;
    logic              perfect;

    always_comb begin
        word     = hash_idx[IDX_W-1] ? table_hi : table_lo;
        hash_hit = word[hash_idx[IDX_W-2:0]];
        perfect  = is_match ^ mode.inverse;
        if (mode.promisc) begin
            accept = 1'b1;
        end else if (is_bcast) begin
            accept = !mode.bcast_block;
        end else if (is_mcast) begin
            if (mode.all_mcast)
                accept = 1'b1;
            else if (mode.hash_perfect || mode.hash_only)
                accept = hash_hit;
            else
                accept = 1'b0;
        end else if (mode.hash_only) begin
            accept = hash_hit;
        end else begin
            accept = perfect;
        end
    end

endmodule

// File: rtl/dstaddr_filter.sv
module dstaddr_filter
    import daf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_IDX_W = 6,
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1),
    localparam int WORD_W = 2 ** (HASH_IDX_W - 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    addr_start,
    input  logic                    addr_valid,
    input  logic [7:0]              addr_byte,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic [WORD_W-1:0]       hash_lo,
    input  logic [WORD_W-1:0]       hash_hi,
    input  logic                    mode_promisc,
    input  logic                    mode_all_mcast,
    input  logic                    mode_hash_perfect,
    input  logic                    mode_hash_only,
    input  logic                    mode_inverse,
    input  logic                    mode_bcast_block,
    output logic                    frame_accept,
    output logic                    decision_valid
);

    logic                  take, first, dec_valid;
    logic [CNT_W-1:0]      byte_idx;
    logic [HASH_IDX_W-1:0] hash_idx;
    logic                  is_match, is_bcast, is_mcast;
    logic                  accept;
    daf_mode_t             mode;

    assign mode = '{promisc:      mode_promisc,
                    all_mcast:    mode_all_mcast,
                    hash_perfect: mode_hash_perfect,
                    hash_only:    mode_hash_only,
                    inverse:      mode_inverse,
                    bcast_block:  mode_bcast_block};

    daf_fsm #(.ADDR_BYTES(ADDR_BYTES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_start (addr_start),
        .in_valid (addr_valid),
        .take     (take),
        .first    (first),
        .byte_idx (byte_idx),
        .dec_valid(dec_valid)
    );

    daf_crc #(.IDX_W(HASH_IDX_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .first   (first),
        .data    (addr_byte),
        .hash_idx(hash_idx)
    );

    daf_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .first   (first),
        .byte_idx(byte_idx),
        .data    (addr_byte),
        .station (station_addr),
        .is_match(is_match),
        .is_bcast(is_bcast),
        .is_mcast(is_mcast)
    );

    daf_decide #(.IDX_W(HASH_IDX_W)) u_dec (
        .mode    (mode),
        .hash_idx(hash_idx),
        .table_lo(hash_lo),
        .table_hi(hash_hi),
        .is_match(is_match),
        .is_bcast(is_bcast),
        .is_mcast(is_mcast),
        .accept  (accept)
    );

    always_comb begin
        decision_valid = dec_valid;
        frame_accept   = dec_valid && accept;
    end

    // R4
    promisc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid && mode_promisc |-> frame_accept);

    // R5
    bcast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid && is_bcast && !mode_promisc && mode_bcast_block |-> !frame_accept);

    // R5
    bcast_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid && is_bcast && !mode_bcast_block |-> frame_accept);

    // R8
    mcast_default_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid && is_mcast && !is_bcast && !mode_promisc && !mode_all_mcast
        && !mode_hash_perfect && !mode_hash_only |-> !frame_accept);

    // R1
    no_idle_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !decision_valid |-> !frame_accept);

endmodule

// File: tb/dstaddr_filter_test.sv
module dstaddr_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_start = 1'b0;
    logic        addr_valid = 1'b0;
    logic [7:0]  addr_byte = 8'h00;
    logic [47:0] station_addr = 48'h5544_3322_1100;
    logic [31:0] hash_lo = 32'h0;
    logic [31:0] hash_hi = 32'h0;
    logic        m_prom = 0, m_allm = 0, m_hp = 0, m_ho = 0, m_inv = 0, m_bblk = 0;
    logic        frame_accept, decision_valid;

    always #2.5 clk = ~clk;

    dstaddr_filter uut (
        .clk(clk), .rst_n(rst_n),
        .addr_start(addr_start), .addr_valid(addr_valid), .addr_byte(addr_byte),
        .station_addr(station_addr), .hash_lo(hash_lo), .hash_hi(hash_hi),
        .mode_promisc(m_prom), .mode_all_mcast(m_allm), .mode_hash_perfect(m_hp),
        .mode_hash_only(m_ho), .mode_inverse(m_inv), .mode_bcast_block(m_bblk),
        .frame_accept(frame_accept), .decision_valid(decision_valid)
    );

    int    checks = 0;
    int    fails = 0;
    string scen = "";

    // independent hash index computation, bit by bit over the whole address
    function automatic int ref_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[31] ^ a[i];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return int'(c >> 26);
    endfunction

    function automatic logic ref_hit(input logic [47:0] a);
        int idx = ref_index(a);
        if (idx >= 32) return hash_hi[idx - 32];
        return hash_lo[idx];
    endfunction

    function automatic logic ref_decide(input logic [47:0] a, output string tag);
        logic mc = a[0];
        logic bc = (a == {48{1'b1}});
        logic eq = (a == station_addr);
        if (m_prom) begin tag = "R4 R10"; return 1'b1; end
        if (bc) begin tag = "R5"; return !m_bblk; end
        if (mc) begin
            if (m_allm) begin tag = "R6"; return 1'b1; end
            if (m_hp || m_ho) begin tag = "R3 R7"; return ref_hit(a); end
            tag = "R8"; return 1'b0;
        end
        if (m_ho) begin tag = "R3 R9"; return ref_hit(a); end
        if (m_inv) begin tag = "R10 R12"; return !eq; end
        tag = m_hp ? "R7 R12" : "R8 R12";
        return eq;
    endfunction

    // cycle-by-cycle reference model
    int          m_n = 0;
    logic [47:0] m_addr = '0;
    logic        exp_valid = 1'b0;
    logic        exp_acc = 1'b0;
    string       exp_tag = "";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 0;
            exp_valid = 1'b0;
        end else begin
            exp_valid = 1'b0;
            if (addr_valid && addr_start) begin
                m_addr = '0;
                m_addr[7:0] = addr_byte;
                m_n = 1;
            end else if (addr_valid && m_n > 0) begin
                m_addr[8*m_n +: 8] = addr_byte;
                m_n++;
            end
            if (m_n == 6) begin
                exp_valid = 1'b1;
                exp_acc = ref_decide(m_addr, exp_tag);
                m_n = 0;
            end
        end
    end

    always @(negedge clk) begin
        checks++;
        if (!rst_n) begin
            if (decision_valid !== 1'b0) begin
                fails++;
                $display("FAIL R1 decision_valid in reset act=%b exp=0", decision_valid);
            end
        end else begin
            if (decision_valid !== exp_valid) begin
                fails++;
                $display("FAIL R2 %s decision_valid act=%b exp=%b", scen, decision_valid, exp_valid);
            end
            if (exp_valid) begin
                checks++;
                if (frame_accept !== exp_acc) begin
                    fails++;
                    $display("FAIL %s %s addr=%h frame_accept act=%b exp=%b",
                             exp_tag, scen, m_addr, frame_accept, exp_acc);
                end
            end
        end
    end

    task automatic send_addr(input logic [47:0] a, input int gap, input logic with_start);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            addr_valid = 1'b1;
            addr_start = with_start && (k == 0);
            addr_byte  = a[8*k +: 8];
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                addr_valid = 1'b0;
                addr_start = 1'b0;
                addr_byte  = 8'hEE;
            end
        end
        @(negedge clk);
        addr_valid = 1'b0;
        addr_start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    logic [47:0] addrs [6];

    initial begin
        addrs[0] = 48'h5544_3322_1100;   // station
        addrs[1] = 48'h5544_3322_1200;   // one byte off
        addrs[2] = 48'hABCD_EF01_2346;   // other unicast
        addrs[3] = 48'h0100_5E00_0001;   // multicast
        addrs[4] = 48'h1234_5678_9A03;   // multicast
        addrs[5] = {48{1'b1}};           // broadcast
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int cfg = 0; cfg < 3; cfg++) begin
            hash_lo = 32'h0;
            hash_hi = 32'h0;
            if (cfg == 0) begin
                // set only the bits indexed by the station and one multicast
                for (int s = 0; s < 2; s++) begin
                    int ix = ref_index(s == 0 ? addrs[0] : addrs[3]);
                    if (ix >= 32) hash_hi[ix - 32] = 1'b1; else hash_lo[ix] = 1'b1;
                end
            end else if (cfg == 1) begin
                hash_lo = 32'hA5C3_0F96;
                hash_hi = 32'h3C69_D2E1;
            end else begin
                hash_lo = 32'hFFFF_FFFF;
                hash_hi = 32'hFFFF_FFFF;
            end
            for (int m = 0; m < 64; m++) begin
                {m_bblk, m_inv, m_ho, m_hp, m_allm, m_prom} = 6'(m);
                for (int a = 0; a < 6; a++) begin
                    scen = "sweep";
                    send_addr(addrs[a], (a + m) % 3, 1'b1);
                end
            end
        end

        // R11: restart mid-address, then start-less bytes while idle
        {m_bblk, m_inv, m_ho, m_hp, m_allm, m_prom} = 6'b000000;
        scen = "R11 restart";
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            addr_valid = 1'b1;
            addr_start = (k == 0);
            addr_byte  = 8'h77;
        end
        send_addr(addrs[0], 0, 1'b1);
        scen = "R11 no-start";
        send_addr(addrs[0], 1, 1'b0);
        // R2: back-to-back frames without idle gap
        scen = "R2 back-to-back";
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                addr_valid = 1'b1;
                addr_start = (k == 0);
                addr_byte  = addrs[r][8*k +: 8];
            end
        end
        @(negedge clk);
        addr_valid = 1'b0;
        addr_start = 1'b0;
        repeat (4) @(negedge clk);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

endmodule